// File: doc/BRIEF.md
# Display Driver Serial Streamer

This block sends one frame of display data to an external shift-register display driver over a three-wire link: a serial clock, a data line and a latch-load strobe. A fourth output gates the driver through a blanking line whose active level is chosen by a polarity input. A frame holds up to 84 bits. It is loaded in parallel from display memory when a start request is accepted. A shift-limit value sets how many of those bits go out on the wire.

The serial clock runs at one quarter of the system clock rate. Each bit period is four system cycles: two low, then two high. Data changes only when the serial clock falls, so the driver can sample it on the rising edge. Bits leave from index M-1 down to index 0. After the last bit, the load strobe goes high for one serial-clock period and then returns low. Between frames the serial clock rests high. A new start request is accepted only once the load pulse has ended.

Top module: `disp_stream_tx`

## Requirements
- R1: While reset is asserted, and in the cycle after it, ser_clk is 1, ser_data is 0, latch_load is 0, busy is 0 and blank_out is 1.
- R2: During a frame, ser_clk repeats a four-cycle pattern: 0, 0, 1, 1.
- R3: ser_data changes only in a cycle where ser_clk has just gone from 1 to 0.
- R4: With shift limit M between 1 and 84, a frame gives exactly M rising edges of ser_clk. Bit k of the frame, for k = M-1 down to 0, is on ser_data across the k-th falling-to-rising window. The order is highest index first.
- R5: A shift limit above 84 is treated as 84.
- R6: latch_load stays 0 while bits are shifting. It is 1 for exactly four cycles straight after the high half of the last bit, with ser_clk held at 1, and then returns to 0.
- R7: busy is 1 from the cycle after an accepted start until the load pulse ends. A start request, a new frame_bits value or a new shift_limit value during that time has no effect on the frame being sent.
- R8: One cycle after each clock edge, blank_out equals enable_level when disp_enable is 1, and the inverse of enable_level when disp_enable is 0.
- R9: A start request with a shift limit of 0 is ignored: busy stays 0 and the serial lines do not move.
- R10: When idle, ser_clk is 1 and latch_load is 0. ser_data keeps the last bit sent, which is bit 0 of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start request, taken only when idle |
| frame_bits | input | 84 | Parallel frame data, captured when a start is accepted |
| shift_limit | input | 7 | Number of bits to send (M) |
| disp_enable | input | 1 | 1 enables the display driver, 0 blanks it |
| enable_level | input | 1 | Level of blank_out that enables the driver |
| ser_clk | output | 1 | Serial clock to the driver |
| ser_data | output | 1 | Serial data to the driver |
| latch_load | output | 1 | Latch-load strobe to the driver |
| blank_out | output | 1 | Driver gate line |
| busy | output | 1 | A frame or its load pulse is in progress |

## Verification
The bench runs frames of several lengths and compares them on every cycle with a behavioural model. The cases are:
- A short asymmetric byte, which exposes a reversed bit order.
- A one-bit frame, which exposes off-by-one errors at the first and last bit.
- A full 84-bit frame with a pattern that differs at both ends.
- A limit of 100, which separates clamping from wrap-around.

Further cases send a zero limit, retrigger the block and change its inputs during a frame, and start a new frame back to back with the last one. These show whether requests are ignored at the right times. All four combinations of the blanking inputs are also applied.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } dss_state_t;
endpackage

// File: rtl/dss_rate_gen.sv
module dss_rate_gen #(
  parameter int DIV  = 4,
  parameter int PH_W = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic wrap,
  output logic hi_next
);
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0] phase_q;
  logic [PH_W:0]   phase_inc;

  assign phase_inc = {1'b0, phase_q} + 1'b1;
  assign wrap      = (phase_q == PH_W'(DIV - 1));
  assign hi_next   = !wrap && (phase_inc >= (PH_W + 1)'(HALF));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_inc[PH_W-1:0];
    end
  end
endmodule

// File: rtl/dss_frame_store.sv
module dss_frame_store #(
  parameter int FRAME_MAX = 84,
  parameter int LIM_W     = $clog2(FRAME_MAX + 1),
  parameter int IDX_W     = $clog2(FRAME_MAX)
) (
  input  logic                 clk,
  input  logic                 capture,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LIM_W-1:0]     limit_in,
  input  logic [IDX_W-1:0]     idx,
  output logic [LIM_W-1:0]     limit_clamped,
  output logic                 sel_bit
);
  logic [FRAME_MAX-1:0] buf_q;

  // limits above the frame size saturate at the frame size
  assign limit_clamped = (limit_in > LIM_W'(FRAME_MAX)) ? LIM_W'(FRAME_MAX) : limit_in;

  // no reset on the storage so it maps onto plain registers or memory
  always_ff @(posedge clk) begin
    if (capture) buf_q <= frame_in;
  end

  // in the capture cycle the first bit comes straight from the input
  assign sel_bit = capture ? frame_in[idx] : buf_q[idx];
endmodule

// File: rtl/dss_blank.sv
module dss_blank (
  input  logic clk,
  input  logic rst,
  input  logic disp_enable,
  input  logic enable_level,
  output logic blank_out
);
  always_ff @(posedge clk) begin
    if (rst) blank_out <= 1'b1;
    else     blank_out <= disp_enable ? enable_level : !enable_level;
  end
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int FRAME_MAX = 84,
  parameter int LIM_W     = $clog2(FRAME_MAX + 1),
  parameter int IDX_W     = $clog2(FRAME_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LIM_W-1:0] limit_c,
  input  logic             wrap,
  input  logic             hi_next,
  input  logic             sel_bit,
  output logic [IDX_W-1:0] idx_req,
  output logic             capture,
  output logic             run,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             latch_load,
  output logic             busy
);
  dss_state_t       st;
  logic [IDX_W-1:0] bit_q;
  logic             accept;

  assign accept  = (st == ST_IDLE) && start && (limit_c != '0);
  assign capture = accept;
  assign idx_req = accept ? IDX_W'(limit_c - LIM_W'(1)) : (bit_q - IDX_W'(1));
  assign run     = (st != ST_IDLE);
  assign busy    = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      bit_q      <= '0;
      ser_clk    <= 1'b1;
      ser_data   <= 1'b0;
      latch_load <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st       <= ST_SHIFT;
            bit_q    <= IDX_W'(limit_c - LIM_W'(1));
            ser_clk  <= 1'b0;
            ser_data <= sel_bit;
          end
        end
        ST_SHIFT: begin
          if (wrap) begin
            if (bit_q == '0) begin
              st         <= ST_LOAD;
              ser_clk    <= 1'b1;
              latch_load <= 1'b1;
            end else begin
              bit_q    <= bit_q - IDX_W'(1);
              ser_clk  <= 1'b0;
              ser_data <= sel_bit;
            end
          end else begin
            ser_clk <= hi_next;
          end
        end
        ST_LOAD: begin
          if (wrap) begin
            st         <= ST_IDLE;
            latch_load <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_load_low_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SHIFT) |-> !latch_load);

  p_load_width_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_load) |-> ($past(latch_load, 2) && $past(latch_load, 3) && $past(latch_load, 4)));

  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> $fell(ser_clk));

  p_clk_low_two_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |=> !ser_clk);

  p_clk_high_two_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(ser_clk) && (st == ST_SHIFT)) |=> ser_clk);

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (ser_clk && !latch_load));
endmodule

// File: rtl/disp_stream_tx.sv
module disp_stream_tx #(
  parameter int FRAME_MAX = 84,
  parameter int CLK_DIV   = 4,
  parameter int LIM_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] frame_bits,
  input  logic [LIM_W-1:0]     shift_limit,
  input  logic                 disp_enable,
  input  logic                 enable_level,
  output logic                 ser_clk,
  output logic                 ser_data,
  output logic                 latch_load,
  output logic                 blank_out,
  output logic                 busy
);
  localparam int IDX_W = $clog2(FRAME_MAX);

  logic             wrap, hi_next, run, capture, sel_bit;
  logic [IDX_W-1:0] idx_req;
  logic [LIM_W-1:0] limit_c;

  dss_rate_gen #(.DIV(CLK_DIV)) u_rate (
    .clk(clk), .rst(rst), .run(run), .wrap(wrap), .hi_next(hi_next)
  );

  dss_frame_store #(.FRAME_MAX(FRAME_MAX), .LIM_W(LIM_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .capture(capture), .frame_in(frame_bits), .limit_in(shift_limit),
    .idx(idx_req), .limit_clamped(limit_c), .sel_bit(sel_bit)
  );

  dss_ctrl #(.FRAME_MAX(FRAME_MAX), .LIM_W(LIM_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .limit_c(limit_c), .wrap(wrap),
    .hi_next(hi_next), .sel_bit(sel_bit), .idx_req(idx_req), .capture(capture),
    .run(run), .ser_clk(ser_clk), .ser_data(ser_data), .latch_load(latch_load),
    .busy(busy)
  );

  dss_blank u_blank (
    .clk(clk), .rst(rst), .disp_enable(disp_enable), .enable_level(enable_level),
    .blank_out(blank_out)
  );
endmodule

// File: tb/sim_disp_stream_tx.sv
module sim_disp_stream_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [83:0] frame_bits = '0;
  logic [6:0]  shift_limit = '0;
  logic        disp_enable = 1'b0;
  logic        enable_level = 1'b0;
  logic        ser_clk, ser_data, latch_load, blank_out, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 0;

  always #5 clk = ~clk;

  disp_stream_tx u0 (
    .clk(clk), .rst(rst), .start(start), .frame_bits(frame_bits),
    .shift_limit(shift_limit), .disp_enable(disp_enable),
    .enable_level(enable_level), .ser_clk(ser_clk), .ser_data(ser_data),
    .latch_load(latch_load), .blank_out(blank_out), .busy(busy)
  );

  // behavioural reference model
  bit          m_run = 0;
  int          m_cnt = 0;
  int          m_lim = 0;
  logic [83:0] m_frame = '0;
  logic        m_hold = 1'b0;
  logic        m_blank = 1'b1;

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      m_run = 0; m_cnt = 0; m_hold = 1'b0; m_blank = 1'b1;
    end else begin
      m_blank = disp_enable ? enable_level : !enable_level;
      if (!m_run) begin
        if (start && shift_limit != 0) begin
          m_run = 1; m_cnt = 0;
          m_lim = (shift_limit > 84) ? 84 : int'(shift_limit);
          m_frame = frame_bits;
        end
      end else begin
        m_cnt++;
        if (m_cnt == 4 * m_lim) m_hold = m_frame[0];
        if (m_cnt == 4 * m_lim + 4) m_run = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, plus edge counting and data-change rule
  logic prev_clk = 1'b1, prev_data = 1'b0, prev_busy = 1'b0;
  int   rises = 0;
  int   exp_rises = 0;

  always @(negedge clk) begin
    if (armed) begin
      logic e_clk, e_data, e_load;
      if (m_run && m_cnt < 4 * m_lim) begin
        e_clk = (m_cnt % 4) >= 2; e_data = m_frame[m_lim - 1 - m_cnt / 4]; e_load = 1'b0;
      end else if (m_run) begin
        e_clk = 1'b1; e_data = m_hold; e_load = 1'b1;
      end else begin
        e_clk = 1'b1; e_data = m_hold; e_load = 1'b0;
      end
      check(rst ? "R1 ser_clk" : "R2 ser_clk", int'(ser_clk), int'(e_clk));
      check(rst ? "R1 ser_data" : "R4 ser_data", int'(ser_data), int'(e_data));
      check(rst ? "R1 latch_load" : "R6 latch_load", int'(latch_load), int'(e_load));
      check(rst ? "R1 busy" : "R7 busy", int'(busy), int'(m_run));
      check(rst ? "R1 blank_out" : "R8 blank_out", int'(blank_out), int'(m_blank));
      if (!rst) begin
        // R3: data may only move together with a falling serial clock
        if (ser_data !== prev_data) check("R3 data change on fall", int'(prev_clk && !ser_clk), 1);
        if (!prev_clk && ser_clk) rises++;
        if (busy && !prev_busy) begin rises = 0; exp_rises = m_lim; end
        // R4/R5: rising-edge count equals the (clamped) limit
        if (!busy && prev_busy) check("R4 R5 rising edge count", rises, exp_rises);
        if (!busy) check("R10 idle lines", int'(ser_clk && !latch_load), 1);
      end
      prev_clk = ser_clk; prev_data = ser_data; prev_busy = busy;
    end
  end

  task automatic send(input logic [83:0] d, input int lim);
    int eff;
    eff = (lim > 84) ? 84 : lim;
    @(negedge clk);
    start = 1'b1; frame_bits = d; shift_limit = 7'(lim);
    @(negedge clk);
    start = 1'b0;
    repeat (4 * eff + 6) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset blank", int'(blank_out), 1);
    check("R1 reset clk", int'(ser_clk), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset busy", int'(busy), 0);
    // R8: every blanking combination
    for (int i = 0; i < 4; i++) begin
      disp_enable = i[0]; enable_level = i[1];
      @(negedge clk);
    end
    disp_enable = 1'b1; enable_level = 1'b1;
    // R4: short asymmetric byte
    send(84'hA5, 8);
    // R4: single-bit frame
    send(84'h1, 1);
    // R4: full frame with different ends
    send({4'hC, 16'h1234, 64'h0F0F_F0F0_3C3C_5A5B}, 84);
    // R5: limit above the frame size
    send({4'h9, 16'hBEEF, 64'hDEAD_0001_8000_7FFE}, 100);
    // R9: zero limit is ignored
    @(negedge clk);
    start = 1'b1; shift_limit = 7'd0; frame_bits = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R9 zero limit ignored busy", int'(busy), 0);
      check("R9 zero limit ignored clk", int'(ser_clk), 1);
    end
    // R7: retrigger and input changes mid-frame
    @(negedge clk);
    start = 1'b1; frame_bits = 84'h3C; shift_limit = 7'd8;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; frame_bits = '1; shift_limit = 7'd20;
    @(negedge clk);
    check("R7 busy kept", int'(busy), 1);
    start = 1'b0;
    repeat (30) @(negedge clk);
    // back to back: hold start high across the end of a frame
    start = 1'b1; frame_bits = 84'h6; shift_limit = 7'd3;
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule